// File: doc/BRIEF.md
# Secure RAM Control Register Unit

This unit holds the 8-bit mode and enable register that governs a protected on-chip RAM. Software reaches it over a simple single-cycle register bus. The unit enforces three kinds of protection on writes. An external lock input blocks all writes. The mode bits are frozen while the RAM is enabled. While a reset sequence runs, no write is accepted unless it asks for a reset. Every refused write gives a one-cycle error response.

The mode bits are silent access, remanence prevention and tamper erase. They act on the bus-clock outputs at once. The enable bit takes a different path. It reaches the slow core clock domain through a toggle handshake. A busy flag stays set until the core domain has acknowledged the new value.

A reset request wipes the register and drives the core-side enable back to 0. It can come from a software write or from a tamper pulse while tamper erase is armed. A tamper-started reset first raises a one-cycle erase request for the RAM and its stored key. The reset finishes only after the erase logic reports done. Software polls a busy register to see when the reset is over.

Top module: `sramctl_top`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the busy register (address 1) reads 0x00, and `coreEnable`, `eraseReq`, `silentAccess`, `remanenceEn` and `err` are all 0.
- R2: Control register layout: bit 7 silent access, bit 6 remanence prevention, bit 4 tamper erase, bit 1 enable, bit 0 reset request (reads 1 while a reset runs). Bits 5, 3 and 2 always read 0, and writing them has no effect.
- R3: A write that is accepted and changes bits 7, 6 or 4 updates `silentAccess` and `remanenceEn` in the next cycle, and it does not set any busy flag.
- R4: A write that changes bit 1 updates the readback at once. It sets busy bit 1 (address 1) until the core domain acknowledges, and `coreEnable` takes the new value before busy bit 1 clears. A control write without bit 0 is refused with `err` while busy bit 1 is set.
- R5: While enable reads 1, a write that would change bits 7, 6 or 4 leaves them unchanged and raises `err`. The enable bit in the same write is still applied.
- R6: A write with bit 0 set discards every other bit of that write and clears the register. It sets busy bit 0 and control bit 0, and ends with `coreEnable` at 0 before busy bit 0 clears.
- R7: While busy bit 0 is set, a write without bit 0 is refused with `err` and changes nothing. A write with bit 0 is accepted silently, and reads of both registers are allowed.
- R8: While `wpLock` is 1, every write is ignored and raises `err`.
- R9: A `tamper` pulse while tamper erase is 1 and no reset runs raises `eraseReq` for exactly one cycle, in the next cycle. It starts a reset that stays busy until `eraseDone` arrives.
- R10: A `tamper` pulse is ignored when tamper erase is 0 or a reset is already running.
- R11: A write to any address other than 0 raises `err`. A read of an address other than 0 or 1 returns 0 and raises `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset, bus domain |
| coreClk | input | 1 | Slow core clock |
| coreRstN | input | 1 | Active-low asynchronous reset, core domain |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address (0 control, 1 busy) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rdEn` |
| err | output | 1 | One-cycle error response after a refused access |
| wpLock | input | 1 | External write lock |
| tamper | input | 1 | Single-cycle tamper event |
| eraseDone | input | 1 | Erase of RAM and key finished |
| eraseReq | output | 1 | One-cycle erase request |
| silentAccess | output | 1 | Silent access mode, bus domain |
| remanenceEn | output | 1 | Remanence prevention enable, bus domain |
| coreEnable | output | 1 | RAM enable in the core domain |
| syncBusy | output | 2 | Bit 1 enable crossing busy, bit 0 reset busy |

## Verification
The assertions assume the following about the inputs. `tamper` is a single-cycle pulse. `eraseDone` comes only while an erase is pending. `wrEn` and `rdEn` are never high together. Both resets are released together. The bench drives every bus strobe for exactly one bus cycle, and it changes inputs only on the falling edge. It pulses `tamper` and `eraseDone` one cycle each and raises `eraseDone` only after it has seen `eraseReq`. It holds `rstN` and `coreRstN` low together from time zero. It waits for the busy flags to clear before starting the next scenario, except where a scenario checks the refusal of a write made while busy.

// File: rtl/sramctl_pkg.sv
package sramctl_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_SILENT = 7;
  localparam int BIT_DRP    = 6;
  localparam int BIT_TAMPER = 4;
  localparam int BIT_ENABLE = 1;
  localparam int BIT_RESET  = 0;
  localparam logic [REG_W-1:0] MODE_MASK =
    (REG_W'(1) << BIT_SILENT) | (REG_W'(1) << BIT_DRP) | (REG_W'(1) << BIT_TAMPER);

  typedef struct packed {
    logic       clearAll;
    logic       loadMode;
    logic [2:0] modeVal;    // {silent, drp, tamper}
    logic       loadEnable;
    logic       enableVal;
    logic       launch;
    logic       launchVal;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ERASE,
    ST_DRAIN,
    ST_SETTLE
  } rstState_t;
endpackage

// File: rtl/sramctl_sync.sv
module sramctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/sramctl_coresync.sv
module sramctl_coresync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic coreClk,
  input  logic coreRstN,
  input  logic reqTgl,
  input  logic reqData,
  output logic ackTgl,
  output logic coreEnable
);
  logic reqSeen;
  logic lastQ;
  logic enableQ;

  sramctl_sync #(.STAGES(SYNC_STAGES)) reqSync (
    .clk (coreClk),
    .rstN(coreRstN),
    .din (reqTgl),
    .dout(reqSeen)
  );

  // reqData is held stable by the bus side while the toggle is in flight
  always_ff @(posedge coreClk or negedge coreRstN) begin
    if (!coreRstN) begin
      lastQ   <= 1'b0;
      enableQ <= 1'b0;
    end else if (reqSeen != lastQ) begin
      lastQ   <= reqSeen;
      enableQ <= reqData;
    end
  end

  assign ackTgl     = lastQ;
  assign coreEnable = enableQ;
endmodule

// File: rtl/sramctl_datapath.sv
module sramctl_datapath
  import sramctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  input  logic      ackTgl,
  output logic      silentQ,
  output logic      drpQ,
  output logic      tamperQ,
  output logic      enableQ,
  output logic      reqTgl,
  output logic      reqData,
  output logic      hsPending
);
  logic reqTglQ;
  logic reqDataQ;
  logic ackSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      silentQ <= 1'b0;
      drpQ    <= 1'b0;
      tamperQ <= 1'b0;
      enableQ <= 1'b0;
    end else if (strobe.clearAll) begin
      silentQ <= 1'b0;
      drpQ    <= 1'b0;
      tamperQ <= 1'b0;
      enableQ <= 1'b0;
    end else begin
      if (strobe.loadMode) begin
        silentQ <= strobe.modeVal[2];
        drpQ    <= strobe.modeVal[1];
        tamperQ <= strobe.modeVal[0];
      end
      if (strobe.loadEnable) enableQ <= strobe.enableVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqTglQ  <= 1'b0;
      reqDataQ <= 1'b0;
    end else if (strobe.launch) begin
      reqTglQ  <= ~reqTglQ;
      reqDataQ <= strobe.launchVal;
    end
  end

  sramctl_sync #(.STAGES(SYNC_STAGES)) ackSync (
    .clk (clk),
    .rstN(rstN),
    .din (ackTgl),
    .dout(ackSeen)
  );

  assign reqTgl    = reqTglQ;
  assign reqData   = reqDataQ;
  assign hsPending = reqTglQ ^ ackSeen;
endmodule

// File: rtl/sramctl_control.sv
module sramctl_control
  import sramctl_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              wpLock,
  input  logic              tamper,
  input  logic              eraseDone,
  input  logic              silentQ,
  input  logic              drpQ,
  input  logic              tamperQ,
  input  logic              enableQ,
  input  logic              hsPending,
  output dpStrobe_t         strobe,
  output logic [REG_W-1:0]  rdata,
  output logic              err,
  output logic              eraseReq,
  output logic              resetBusy
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_BUSY = ADDR_W'(1);

  rstState_t        stateQ, stateD;
  logic             errQ, eraseQ;
  logic             idle, ctrlHit, wrOk, tamperHit, swHit, normalWr, modeDiff, refuse;
  logic [REG_W-1:0] ctrlImage;

  assign idle      = (stateQ == ST_IDLE);
  assign ctrlHit   = (addr == ADDR_CTRL);
  assign wrOk      = wrEn && !wpLock && ctrlHit;
  assign tamperHit = tamper && tamperQ && idle;
  assign swHit     = wrOk && wdata[BIT_RESET] && idle;
  assign normalWr  = wrOk && !wdata[BIT_RESET] && idle && !hsPending && !tamperHit;

  always_comb begin
    ctrlImage             = '0;
    ctrlImage[BIT_SILENT] = silentQ;
    ctrlImage[BIT_DRP]    = drpQ;
    ctrlImage[BIT_TAMPER] = tamperQ;
    ctrlImage[BIT_ENABLE] = enableQ;
  end

  assign modeDiff = ((wdata ^ ctrlImage) & MODE_MASK) != '0;

  // strobes towards the datapath
  always_comb begin
    strobe          = '0;
    strobe.clearAll = tamperHit || swHit;
    strobe.modeVal  = {wdata[BIT_SILENT], wdata[BIT_DRP], wdata[BIT_TAMPER]};
    strobe.enableVal = wdata[BIT_ENABLE];
    if (normalWr) begin
      strobe.loadMode   = !enableQ;
      strobe.loadEnable = (wdata[BIT_ENABLE] != enableQ);
      strobe.launch     = (wdata[BIT_ENABLE] != enableQ);
      strobe.launchVal  = wdata[BIT_ENABLE];
    end
    if (stateQ == ST_DRAIN && !hsPending) begin
      strobe.launch    = 1'b1;
      strobe.launchVal = 1'b0;
    end
  end

  // reset sequencer
  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (tamperHit)  stateD = ST_ERASE;
        else if (swHit) stateD = ST_DRAIN;
      end
      ST_ERASE:  if (eraseDone)  stateD = ST_DRAIN;
      ST_DRAIN:  if (!hsPending) stateD = ST_SETTLE;
      ST_SETTLE: if (!hsPending) stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  // refusal decision for the error response
  always_comb begin
    refuse = 1'b0;
    if (wrEn) begin
      if (wpLock || !ctrlHit)       refuse = 1'b1;
      else if (!idle)               refuse = !wdata[BIT_RESET];
      else if (wdata[BIT_RESET])    refuse = 1'b0;
      else if (tamperHit)           refuse = 1'b1;
      else if (hsPending)           refuse = 1'b1;
      else if (enableQ && modeDiff) refuse = 1'b1;
    end else if (rdEn) begin
      refuse = (addr != ADDR_CTRL) && (addr != ADDR_BUSY);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      errQ   <= 1'b0;
      eraseQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      errQ   <= refuse;
      eraseQ <= tamperHit;
    end
  end

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      if (addr == ADDR_CTRL) begin
        rdata            = ctrlImage;
        rdata[BIT_RESET] = !idle;
      end else if (addr == ADDR_BUSY) begin
        rdata[1] = hsPending;
        rdata[0] = !idle;
      end
    end
  end

  assign err       = errQ;
  assign eraseReq  = eraseQ;
  assign resetBusy = !idle;
endmodule

// File: rtl/sramctl_top.sv
module sramctl_top
  import sramctl_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreClk,
  input  logic              coreRstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              err,
  input  logic              wpLock,
  input  logic              tamper,
  input  logic              eraseDone,
  output logic              eraseReq,
  output logic              silentAccess,
  output logic              remanenceEn,
  output logic              coreEnable,
  output logic [1:0]        syncBusy
);
  dpStrobe_t strobe;
  logic silentQ, drpQ, ctrlTamperEn, ctrlEnable;
  logic reqTgl, reqData, ackTgl, hsPending, resetBusy;

  sramctl_control #(.ADDR_W(ADDR_W)) ctrl (
    .clk, .rstN, .wrEn, .rdEn, .addr, .wdata, .wpLock, .tamper, .eraseDone,
    .silentQ  (silentQ),
    .drpQ     (drpQ),
    .tamperQ  (ctrlTamperEn),
    .enableQ  (ctrlEnable),
    .hsPending(hsPending),
    .strobe   (strobe),
    .rdata, .err, .eraseReq,
    .resetBusy(resetBusy)
  );

  sramctl_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp (
    .clk, .rstN,
    .strobe   (strobe),
    .ackTgl   (ackTgl),
    .silentQ  (silentQ),
    .drpQ     (drpQ),
    .tamperQ  (ctrlTamperEn),
    .enableQ  (ctrlEnable),
    .reqTgl   (reqTgl),
    .reqData  (reqData),
    .hsPending(hsPending)
  );

  sramctl_coresync #(.SYNC_STAGES(SYNC_STAGES)) cs (
    .coreClk, .coreRstN,
    .reqTgl    (reqTgl),
    .reqData   (reqData),
    .ackTgl    (ackTgl),
    .coreEnable(coreEnable)
  );

  assign silentAccess = silentQ;
  assign remanenceEn  = drpQ;
  assign syncBusy     = {hsPending, resetBusy};
endmodule

// File: rtl/sramctl_checker.sv
module sramctl_checker #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              err,
  input logic              wpLock,
  input logic              tamper,
  input logic              eraseReq,
  input logic              silentAccess,
  input logic              remanenceEn,
  input logic              coreEnable,
  input logic [1:0]        syncBusy,
  input logic              tamperEn,
  input logic              enableBit
);
  assert_erase_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |=> !eraseReq);

  assert_tamper_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tamper && tamperEn && !syncBusy[0]) |=> (eraseReq && syncBusy[0]));

  assert_tamper_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (tamper && (!tamperEn || syncBusy[0])) |=> !eraseReq);

  assert_lock_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wpLock) |=> (err && $stable(silentAccess) && $stable(remanenceEn) && $stable(tamperEn)));

  assert_reset_refuse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wpLock && syncBusy[0] && !wdata[0]) |=> (err && $stable(tamperEn) && $stable(silentAccess)));

  assert_reset_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncBusy[0]) |-> (!silentAccess && !remanenceEn && !tamperEn && !enableBit));

  assert_reset_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncBusy[0]) |-> !coreEnable);

  assert_mode_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wpLock && addr == '0 && !wdata[0] && enableBit && !syncBusy[0] && !tamper)
      |=> ($stable(silentAccess) && $stable(remanenceEn) && $stable(tamperEn)));

  assert_busy_refuse_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wpLock && addr == '0 && !wdata[0] && syncBusy[1] && !syncBusy[0]) |=> err);
endmodule

bind sramctl_top sramctl_checker #(.ADDR_W(ADDR_W)) chk (
  .clk, .rstN, .wrEn, .addr, .wdata, .err, .wpLock, .tamper, .eraseReq,
  .silentAccess, .remanenceEn, .coreEnable, .syncBusy,
  .tamperEn (ctrlTamperEn),
  .enableBit(ctrlEnable)
);

// File: tb/sramctl_top_test.sv
module sramctl_top_test;
  logic       clk = 1'b0, coreClk = 1'b0;
  logic       rstN = 1'b0, coreRstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       err;
  logic       wpLock = 1'b0, tamper = 1'b0, eraseDone = 1'b0;
  logic       eraseReq, silentAccess, remanenceEn, coreEnable;
  logic [1:0] syncBusy;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;      // 50 MHz
  always #35 coreClk = ~coreClk;

  sramctl_top uut (
    .clk, .rstN, .coreClk, .coreRstN, .wrEn, .rdEn, .addr, .wdata, .rdata, .err,
    .wpLock, .tamper, .eraseDone, .eraseReq, .silentAccess, .remanenceEn,
    .coreEnable, .syncBusy
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, output logic e);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
    e = err;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d, output logic e);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rdEn = 1'b0;
    e = err;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (syncBusy !== 2'b00 && n < 400) begin
      @(negedge clk);
      n++;
    end
    check({tag, " busy clears"}, syncBusy, 2'b00);
  endtask

  task automatic testReset();
    logic [7:0] d; logic e;
    check("R1 err", err, 1'b0);
    check("R1 eraseReq", eraseReq, 1'b0);
    check("R1 outputs", {silentAccess, remanenceEn, coreEnable}, 3'b000);
    busRead(2'd0, d, e); check("R1 ctrl", d, 8'h00);
    busRead(2'd1, d, e); check("R1 busy", d, 8'h00);
  endtask

  task automatic testModes();
    logic [7:0] d; logic e;
    busWrite(2'd0, 8'hFC, e);
    check("R3 no err", e, 1'b0);
    check("R3 outputs", {silentAccess, remanenceEn}, 2'b11);
    check("R3 no busy", syncBusy, 2'b00);
    busRead(2'd0, d, e); check("R2 reserved bits read 0", d, 8'hD0);
    busWrite(2'd0, 8'h10, e);
    check("R3 clear outputs", {silentAccess, remanenceEn}, 2'b00);
    busRead(2'd0, d, e); check("R2 tamper bit only", d, 8'h10);
    busWrite(2'd0, 8'hD0, e);
  endtask

  task automatic testEnable();
    logic [7:0] d; logic e;
    busWrite(2'd0, 8'hD2, e);
    check("R4 no err", e, 1'b0);
    check("R4 busy set", syncBusy, 2'b10);
    busRead(2'd0, d, e); check("R4 readback", d, 8'hD2);
    busWrite(2'd0, 8'hD0, e);
    check("R4 write while busy refused", e, 1'b1);
    busRead(2'd0, d, e); check("R4 refused write unchanged", d, 8'hD2);
    waitIdle("R4");
    check("R4 core enable", coreEnable, 1'b1);
  endtask

  task automatic testProtect();
    logic [7:0] d; logic e;
    busWrite(2'd0, 8'h02, e);
    check("R5 mode change refused", e, 1'b1);
    busRead(2'd0, d, e); check("R5 modes kept", d, 8'hD2);
    busWrite(2'd0, 8'hD2, e);
    check("R5 same modes accepted", e, 1'b0);
    busWrite(2'd0, 8'h50, e);
    check("R5 err on mode change", e, 1'b1);
    busRead(2'd0, d, e); check("R5 enable applied, modes kept", d, 8'hD0);
    waitIdle("R5");
    check("R5 core disabled", coreEnable, 1'b0);
    busWrite(2'd0, 8'hD2, e);
    waitIdle("R5 re-enable");
  endtask

  task automatic testSoftReset();
    logic [7:0] d; logic e;
    busWrite(2'd0, 8'h13, e);
    check("R6 accepted", e, 1'b0);
    check("R6 reset busy", syncBusy[0], 1'b1);
    check("R6 outputs cleared", {silentAccess, remanenceEn}, 2'b00);
    busRead(2'd0, d, e); check("R6 other bits discarded", d, 8'h01);
    check("R7 read allowed", e, 1'b0);
    busWrite(2'd0, 8'h10, e);
    check("R7 write refused", e, 1'b1);
    busRead(2'd0, d, e); check("R7 nothing changed", d, 8'h01);
    busWrite(2'd0, 8'h01, e);
    check("R7 reset write silent", e, 1'b0);
    busRead(2'd1, d, e); check("R7 busy read allowed", e, 1'b0);
    waitIdle("R6");
    check("R6 core disabled", coreEnable, 1'b0);
    busRead(2'd0, d, e); check("R6 final value", d, 8'h00);
  endtask

  task automatic testLock();
    logic [7:0] d; logic e;
    wpLock = 1'b1;
    busWrite(2'd0, 8'h10, e); check("R8 err", e, 1'b1);
    busWrite(2'd0, 8'h01, e); check("R8 reset write err", e, 1'b1);
    check("R8 no reset", syncBusy, 2'b00);
    wpLock = 1'b0;
    busRead(2'd0, d, e); check("R8 unchanged", d, 8'h00);
  endtask

  task automatic pulseTamper();
    @(negedge clk); tamper = 1'b1;
    @(negedge clk); tamper = 1'b0;
  endtask

  task automatic testTamper();
    logic [7:0] d; logic e;
    pulseTamper();
    check("R10 disarmed no erase", eraseReq, 1'b0);
    check("R10 disarmed no reset", syncBusy, 2'b00);
    busWrite(2'd0, 8'h10, e);
    busRead(2'd0, d, e); check("R10 armed", d, 8'h10);
    pulseTamper();
    check("R9 erase request", eraseReq, 1'b1);
    check("R9 reset busy", syncBusy[0], 1'b1);
    @(negedge clk);
    check("R9 erase one cycle", eraseReq, 1'b0);
    repeat (10) @(negedge clk);
    check("R9 waits for erase done", syncBusy[0], 1'b1);
    pulseTamper();
    check("R10 ignored during reset", eraseReq, 1'b0);
    @(negedge clk); eraseDone = 1'b1;
    @(negedge clk); eraseDone = 1'b0;
    waitIdle("R9");
    busRead(2'd0, d, e); check("R9 cleared", d, 8'h00);
  endtask

  task automatic testAddr();
    logic [7:0] d; logic e;
    busRead(2'd2, d, e);
    check("R11 unmapped read data", d, 8'h00);
    check("R11 unmapped read err", e, 1'b1);
    busWrite(2'd1, 8'h03, e);
    check("R11 busy reg write err", e, 1'b1);
    busRead(2'd1, d, e);
    check("R11 busy read ok", e, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1; coreRstN = 1'b1;
    @(negedge clk);
    testReset();
    testModes();
    testEnable();
    testProtect();
    testSoftReset();
    testLock();
    testTamper();
    testAddr();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule